// File: doc/BRIEF.md
# Per-Class Branch Weight Trainer

This block keeps one fetch-gating weight for each of five branch classes and tunes those weights from what happens at commit. A weight is meant to track how often branches in its class are mispredicted. A downstream accumulator adds up the weights of in-flight instructions and uses the total to hold fetch back.

Each class has two pieces of state: a weight of P bits and a signed error counter of P+N bits. Each committed branch of a class adds the class's current weight to that class's counter. If the branch was mispredicted, the counter also loses 2^P. While the weight is in balance with the misprediction rate, the counter stays near zero.

The counter can leave its range in two ways. Going past its upper end means the weight is too large, so the weight drops by one. Going past its lower end means the weight is too small, so it rises by one. In both cases the counter then restarts from zero. All five weights are presented together on one packed output bus.

Top module: `branch_weight_trainer`

## Requirements
- R1: While reset is asserted and after it is released, the weights are the baseline values, and every counter starts from zero. The baselines are: class 0 (high-confidence conditional) = 8, class 1 (low-confidence conditional) = 40, class 2 (return) = 8, class 3 (high-confidence indirect) = 8 and class 4 (low-confidence indirect) = 40. Class k occupies bits [7k+6:7k] of `weights_o`.
- R2: A class whose valid bit is low in a cycle keeps its weight and its counter unchanged in that cycle.
- R3: Weights never leave the range 1 to 127.
- R4: A weight changes by at most one per cycle. It falls only after a correctly predicted commit and rises only after a mispredicted commit.
- R5: A correctly predicted commit adds the current weight to the counter. If the sum would exceed 16383, the weight drops by one. So with weight 8 and only correct commits, the weight becomes 7 on the 2048th commit.
- R6: A mispredicted commit adds the current weight minus 128 to the counter. If the result would fall below -16384, the weight rises by one.
- R7: After any rise or fall the counter restarts from zero. So at weight 7 the next drop comes after exactly 2341 correct commits.
- R8: The five classes update independently, and any subset can be updated in the same cycle.
- R9: A drop requested at weight 1 leaves the weight at 1, and a rise requested at weight 127 leaves it at 127. In both cases the counter still restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_vld_i | input | 5 | Bit k: a branch of class k committed this cycle |
| commit_miss_i | input | 5 | Bit k: that branch was mispredicted (ignored when bit k of valid is low) |
| weights_o | output | 35 | Current weights, class k in bits [7k+6:7k] |

## Verification
The hardest states to reach are the two saturation bounds. A weight only moves after about 16k/|delta| commits, so reaching 127 takes tens of thousands of commits of nearly all mispredictions. The stimulus holds one class at all-correct and another at all-mispredicted for a long stretch, until both sit at their bounds and have seen further adjustment attempts there. Before that, directed runs from reset measure the exact commit counts between adjustments, and a random phase mixes classes against a bench model.

// File: rtl/branch_weight_trainer.sv
module branch_weight_trainer #(
  parameter int NCLS = 5,
  parameter int P    = 7,
  parameter int N    = 8,
  parameter logic [NCLS*P-1:0] BASE = {7'd40, 7'd8, 7'd8, 7'd40, 7'd8}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   commit_vld_i,
  input  logic [NCLS-1:0]   commit_miss_i,
  output logic [NCLS*P-1:0] weights_o
);
  localparam int CW = P + N;
  localparam logic signed [CW:0] CMAX = (CW+1)'((2**(CW-1)) - 1);
  localparam logic signed [CW:0] CMIN = ~CMAX;
  localparam logic signed [CW:0] PEN  = (CW+1)'(2**P);
  localparam logic [P-1:0] WTOP = '1;
  localparam logic [P-1:0] WBOT = P'(1);

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    logic signed [CW-1:0] cnt_q;
    logic [P-1:0]         w_q;
    logic signed [CW:0]   sum;
    logic                 ovf, unf;

    assign sum = $signed({cnt_q[CW-1], cnt_q})
               + $signed({{(CW+1-P){1'b0}}, w_q})
               - (commit_miss_i[g] ? PEN : '0);
    assign ovf = sum > CMAX;
    assign unf = sum < CMIN;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
        w_q   <= BASE[g*P +: P];
      end else if (commit_vld_i[g]) begin
        if (ovf) begin
          cnt_q <= '0;
          if (w_q > WBOT) w_q <= w_q - 1'b1;
        end else if (unf) begin
          cnt_q <= '0;
          if (w_q != WTOP) w_q <= w_q + 1'b1;
        end else begin
          cnt_q <= sum[CW-1:0];
        end
      end
    end

    assign weights_o[g*P +: P] = w_q;
  end
endmodule

// File: rtl/branch_weight_trainer_chk.sv
module branch_weight_trainer_chk #(
  parameter int NCLS = 5,
  parameter int P    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCLS-1:0]   commit_vld_i,
  input logic [NCLS-1:0]   commit_miss_i,
  input logic [NCLS*P-1:0] weights_o
);
  for (genvar g = 0; g < NCLS; g++) begin : g_chk
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_vld_i[g] |=> $stable(weights_o[g*P +: P]));

    assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (weights_o[g*P +: P] >= P'(1)));

    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (weights_o[g*P +: P] == $past(weights_o[g*P +: P]))
            || (weights_o[g*P +: P] == $past(weights_o[g*P +: P]) + P'(1))
            || (weights_o[g*P +: P] == $past(weights_o[g*P +: P]) - P'(1)));

    assert_rise_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_vld_i[g] && commit_miss_i[g]) |=>
        weights_o[g*P +: P] <= $past(weights_o[g*P +: P]));

    assert_fall_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_vld_i[g] && !commit_miss_i[g]) |=>
        weights_o[g*P +: P] >= $past(weights_o[g*P +: P]));
  end
endmodule

bind branch_weight_trainer branch_weight_trainer_chk #(.NCLS(NCLS), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_vld_i(commit_vld_i),
  .commit_miss_i(commit_miss_i), .weights_o(weights_o));

// File: tb/branch_weight_trainer_bench.sv
module branch_weight_trainer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] vld = '0, miss = '0;
  logic [34:0] wts;
  int checks = 0, fails = 0;
  int mw [5];
  int mc [5];
  bit done = 0;

  always #10 clk = ~clk;

  branch_weight_trainer u_branch_weight_trainer (
    .clk(clk), .rst_n(rst_n), .commit_vld_i(vld), .commit_miss_i(miss), .weights_o(wts));

  function automatic int wout(int k);
    return int'(wts[k*7 +: 7]);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mw[0] = 8; mw[1] = 40; mw[2] = 8; mw[3] = 8; mw[4] = 40;
    for (int k = 0; k < 5; k++) mc[k] = 0;
  endtask

  task automatic model_step(logic [4:0] v, logic [4:0] m);
    for (int k = 0; k < 5; k++) begin
      if (v[k]) begin
        int s = mc[k] + mw[k] - (m[k] ? 128 : 0);
        if (s > 16383) begin mc[k] = 0; if (mw[k] > 1) mw[k]--; end
        else if (s < -16384) begin mc[k] = 0; if (mw[k] < 127) mw[k]++; end
        else mc[k] = s;
      end
    end
  endtask

  task automatic tick(logic [4:0] v, logic [4:0] m, string tag, bit cmp);
    @(negedge clk);
    vld = v; miss = m;
    model_step(v, m);
    @(posedge clk); #2;
    if (cmp) for (int k = 0; k < 5; k++) check(tag, wout(k), mw[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    for (int k = 0; k < 5; k++) check("R1 reset value", wout(k), mw[k]);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    for (int k = 0; k < 5; k++) check("R1 after release", wout(k), mw[k]);

    // R2: misses on idle classes are ignored
    for (int i = 0; i < 20; i++) tick(5'b00000, 5'b11111, "R2 idle", 1);

    // R5 / R8: class 0 hits only, class 2 misses only, in parallel
    n = 0;
    do begin tick(5'b00101, 5'b00100, "R8 parallel", 1); n++; end while (wout(0) == 8 && n < 5000);
    check("R5 commits to first drop", n, 2048);
    check("R5 weight after drop", wout(0), 7);
    // R7: counter restarted at zero
    n = 0;
    do begin tick(5'b00001, 5'b00000, "R7 track", 1); n++; end while (wout(0) == 7 && n < 5000);
    check("R7 commits to second drop", n, 2341);
    // R6: class 3 misses, weight 8: per-commit delta -120
    n = 0;
    do begin tick(5'b01000, 5'b01000, "R6 track", 1); n++; end while (wout(3) == 8 && n < 5000);
    check("R6 commits to first rise", n, 137);
    check("R6 weight after rise", wout(3), 9);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] v = 5'($urandom);
      logic [4:0] m = 5'($urandom) & 5'($urandom);
      tick(v, m, "R5 R6 R8 random", 1);
    end

    // R9: push class 0 to floor and class 1 to ceiling
    for (int i = 0; i < 100000; i++) tick(5'b00011, 5'b00010, "R9 saturate", (i % 64) == 0);
    check("R9 floor", wout(0), 1);
    check("R9 ceiling", wout(1), 127);
    for (int k = 0; k < 5; k++) check("R9 model", wout(k), mw[k]);
    tick(5'b00000, 5'b00000, "R2 final", 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule